// File: doc/BRIEF.md
# Serial interrupt frame host

This block is the host end of a shared, open-drain, single-wire interrupt line that runs on the bus clock. It frames each interrupt cycle. It drives a low start pulse, drives the line high for one clock and then releases it for one clock. Next it walks a programmable number of three-clock data slots and drives a stop pulse. In the first clock of every slot it samples the line. A low level means the peripheral that owns that slot is asserting its request.

The requests captured in a cycle are published together when the cycle completes. They appear on a level vector with one bit per slot. A single 8-bit configuration register holds four settings: enable, cycle mode, slot count and start-pulse width. In continuous mode the host opens every cycle itself, back to back. In quiet mode the line rests idle until a peripheral pulls it low. The host then completes that start pulse, so its own share is one clock shorter. Quiet starts are honoured only after at least one complete cycle has run since reset.

The line is modelled as three states: drive low (`drv_low`), drive high (`drv_high`), and released when neither is set. The resolved level comes back on `line_in`. The request vector and the configuration pins are plain level signals. There is no data stream and no back-pressure.

Top module: `sirq_frame_host`

## Requirements
- R1: The configuration register resets to 10h and reads back on `cfg_rdata`. Its fields are: bit 7 enable, bit 6 mode (1 continuous, 0 quiet), bits 5:2 slot-count offset, and bits 1:0 start width. A write on `cfg_we` takes effect at that clock edge.
- R2: With enable at 0, the line level is ignored and the host drives nothing. Clearing enable during a cycle releases the line within two clocks and abandons that cycle without changing `irq_vec`.
- R3: In continuous mode the host opens a cycle by driving low for the full start width. After each stop sequence it opens the next cycle on the clock right after the release clock.
- R4: The start-width code selects the pulse length: 00 gives 4 clocks, 01 gives 6 clocks, 10 gives 8 clocks, and the reserved code 11 gives 4 clocks.
- R5: In quiet mode, once primed, a low level sampled while idle makes the host drive low for the programmed width minus one clock.
- R6: Every start pulse is followed by exactly one clock driven high and then one released clock. The first data slot begins after that.
- R7: A cycle holds 17 plus the slot-count offset data slots, each three clocks long. The host never drives during slots. A low level in a slot's first clock sets bit k of `irq_vec` for slot k.
- R8: The stop pulse is 3 clocks low if the mode is continuous when the last slot ends, and 2 clocks low if it is quiet. Then comes one clock high and one released clock. In quiet mode the host then stays idle until a peripheral starts a cycle.
- R9: `irq_vec` changes only on the first stop clock of a completed cycle, and it holds its value between cycles. Bits at or above the slot count read 0.
- R10: After reset, a low level in quiet mode is ignored until one complete cycle has run.
- R11: Slot count and start width are latched when a cycle opens. A write during a cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current configuration value |
| line_in | input | 1 | Resolved level of the interrupt line |
| drv_low | output | 1 | Host pulls the line low |
| drv_high | output | 1 | Host drives the line high |
| irq_vec | output | 32 | Captured request per slot, 1 = asserted |

## Verification
The hardest state to reach is a peripheral-started cycle in quiet mode, because the host ignores such starts until a full cycle has completed. The stimulus therefore runs a chain of continuous cycles first. It rewrites the configuration during the first slot of each cycle, to show that the cycle in flight keeps its latched width and slot count. The final rewrite switches to quiet mode, which shortens that cycle's stop pulse and leaves the line idle. A modelled peripheral then pulls the line low for one clock, and the bench checks that the host completes the start pulse one clock short.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int SLOT_BASE = 17;
  localparam int SZ_W      = 4;
  localparam int MAX_SLOTS = SLOT_BASE + (1 << SZ_W) - 1;
  localparam int IDX_W     = $clog2(MAX_SLOTS);
  localparam int CNT_W     = 4;
  localparam int CFG_W     = 8;

  localparam logic [CNT_W-1:0] STOP_CONT_LEN  = CNT_W'(3);
  localparam logic [CNT_W-1:0] STOP_QUIET_LEN = CNT_W'(2);
  localparam logic [CFG_W-1:0] CFG_RESET      = 8'h10;

  typedef struct packed {
    logic            en;
    logic            cont;
    logic [SZ_W-1:0] size;
    logic [1:0]      width;
  } sirq_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_START_HI,
    ST_START_TA,
    ST_SLOT,
    ST_STOP,
    ST_STOP_HI,
    ST_STOP_TA
  } sirq_state_e;

  function automatic logic [CNT_W-1:0] start_len(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(6);
      2'b10:   return CNT_W'(8);
      default: return CNT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/sirq_cfg.sv
module sirq_cfg
  import sirq_pkg::*;
#(
  parameter int                W         = CFG_W,
  parameter logic [CFG_W-1:0]  RESET_VAL = CFG_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output sirq_cfg_t    cfg
);

  logic [W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= RESET_VAL;
    else if (we) cfg_q <= wdata;
  end

  assign rdata = cfg_q;
  assign cfg   = sirq_cfg_t'(cfg_q);

  // R1: a write is visible on the next cycle
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == $past(wdata)));

endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sirq_cfg_t     cfg,
  input  logic          sense_n,
  output logic          drv_low,
  output logic          drv_high,
  output logic          open_stb,
  output logic          sample_stb,
  output logic          done_stb,
  output logic [IW-1:0] slot_idx
);

  localparam logic [1:0]    PH_LAST = 2'd2;
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] TWO     = CW'(2);

  sirq_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] last_q, last_d;
  logic [1:0]    ph_q, ph_d;
  logic          primed_q, primed_d;
  logic [CW-1:0] len;
  logic [IW-1:0] last_new;

  assign len      = start_len(cfg.width);
  assign last_new = IW'(SLOT_BASE - 1 + int'(cfg.size));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    last_d   = last_q;
    ph_d     = ph_q;
    primed_d = primed_q;
    open_stb = 1'b0;
    done_stb = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cfg.cont) begin
          open_stb = 1'b1;
          st_d     = ST_START;
          cnt_d    = len - ONE;
          last_d   = last_new;
        end else if (primed_q && !sense_n) begin
          open_stb = 1'b1;
          st_d     = ST_START;
          cnt_d    = len - TWO;
          last_d   = last_new;
        end
      end
      ST_START: begin
        if (cnt_q == '0) st_d = ST_START_HI;
        else             cnt_d = cnt_q - ONE;
      end
      ST_START_HI: st_d = ST_START_TA;
      ST_START_TA: begin
        st_d  = ST_SLOT;
        idx_d = '0;
        ph_d  = 2'd0;
      end
      ST_SLOT: begin
        if (ph_q == PH_LAST) begin
          if (idx_q == last_q) begin
            st_d     = ST_STOP;
            done_stb = 1'b1;
            primed_d = 1'b1;
            cnt_d    = cfg.cont ? (STOP_CONT_LEN - ONE) : (STOP_QUIET_LEN - ONE);
          end else begin
            idx_d = idx_q + IW'(1);
            ph_d  = 2'd0;
          end
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      ST_STOP: begin
        if (cnt_q == '0) st_d = ST_STOP_HI;
        else             cnt_d = cnt_q - ONE;
      end
      ST_STOP_HI: st_d = ST_STOP_TA;
      ST_STOP_TA: begin
        if (cfg.cont) begin
          open_stb = 1'b1;
          st_d     = ST_START;
          cnt_d    = len - ONE;
          last_d   = last_new;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!cfg.en) begin
      st_d     = ST_IDLE;
      open_stb = 1'b0;
      done_stb = 1'b0;
      primed_d = primed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      ph_q     <= 2'd0;
      primed_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
      ph_q     <= ph_d;
      primed_q <= primed_d;
    end
  end

  assign drv_low    = (st_q == ST_START)    || (st_q == ST_STOP);
  assign drv_high   = (st_q == ST_START_HI) || (st_q == ST_STOP_HI);
  assign sample_stb = (st_q == ST_SLOT) && (ph_q == 2'd0);
  assign slot_idx   = idx_q;

  // R2: clearing enable releases the line on the following cycle
  a_r2_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> (!drv_low && !drv_high));

  // R6: the end of the start pulse is followed by a driven-high clock
  a_r6_high_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && cnt_q == '0 && cfg.en) |=> drv_high);

  // R7: the slot index stays inside the latched slot count
  a_r7_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLOT) |-> (idx_q <= last_q));

  // R8: completing the last slot leads straight into the stop pulse
  a_r8_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> drv_low);

  // R10: an unprimed host in quiet mode never opens a cycle
  a_r10_unprimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !primed_q && !cfg.cont) |=> !drv_low);

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture
  import sirq_pkg::*;
#(
  parameter int N  = MAX_SLOTS,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_stb,
  input  logic          sample_stb,
  input  logic [IW-1:0] slot_idx,
  input  logic          req,
  input  logic          done_stb,
  output logic [N-1:0]  vec
);

  logic [N-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (open_stb) begin
      shadow_q <= '0;
    end else if (sample_stb) begin
      for (int k = 0; k < N; k++) begin
        if (slot_idx == IW'(k)) shadow_q[k] <= req;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vec <= '0;
    else if (done_stb) vec <= shadow_q;
  end

  // R9: the published vector moves only when a cycle completes
  a_r9_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done_stb |=> $stable(vec));

  // R9: a new cycle starts from an empty shadow
  a_r9_shadow_clears: assert property (@(posedge clk) disable iff (!rst_n)
    open_stb |=> (shadow_q == '0));

endmodule

// File: rtl/sirq_frame_host.sv
module sirq_frame_host
  import sirq_pkg::*;
#(
  parameter int N = MAX_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             line_in,
  output logic             drv_low,
  output logic             drv_high,
  output logic [N-1:0]     irq_vec
);

  sirq_cfg_t        cfg;
  logic             sense_n;
  logic             open_stb;
  logic             sample_stb;
  logic             done_stb;
  logic [IDX_W-1:0] slot_idx;

  sirq_cfg #(.W(CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  // disabled: the line is seen as permanently high
  assign sense_n = cfg.en ? line_in : 1'b1;

  sirq_seq #(.IW(IDX_W), .CW(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .sense_n    (sense_n),
    .drv_low    (drv_low),
    .drv_high   (drv_high),
    .open_stb   (open_stb),
    .sample_stb (sample_stb),
    .done_stb   (done_stb),
    .slot_idx   (slot_idx)
  );

  sirq_capture #(.N(N), .IW(IDX_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_stb   (open_stb),
    .sample_stb (sample_stb),
    .slot_idx   (slot_idx),
    .req        (!sense_n),
    .done_stb   (done_stb),
    .vec        (irq_vec)
  );

  // R7: the host never fights a peripheral during a sample clock
  a_r7_no_drive_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!drv_low && !drv_high));

endmodule

// File: tb/sirq_frame_host_test.sv
module sirq_frame_host_test;
  import sirq_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic                 cfg_we;
  logic [7:0]           cfg_wdata;
  logic [7:0]           cfg_rdata;
  logic                 periph_low;
  logic                 line_in;
  logic                 drv_low;
  logic                 drv_high;
  logic [MAX_SLOTS-1:0] irq_vec;

  assign line_in = !(drv_low || periph_low);

  sirq_frame_host uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .line_in   (line_in),
    .drv_low   (drv_low),
    .drv_high  (drv_high),
    .irq_vec   (irq_vec)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int expect_gap = -1;
  logic [31:0] last_vec = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic quiet_window(input int cycles, input string tag);
    int drove = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (drv_low || drv_high) drove++;
    end
    chk(drove == 0, tag, drove, 0);
  endtask

  // one full interrupt cycle; qinit = peripheral opens it
  task automatic run_frame(input bit qinit, input int w, input int n, input logic [31:0] req,
                           input int stop_len, input bit mid_en, input logic [7:0] mid_val);
    int lowcnt = 0;
    int guard = 0;
    int slot_drive = 0;
    logic [31:0] exp_vec;
    exp_vec = (n >= 32) ? req : (req & ((32'd1 << n) - 32'd1));
    if (qinit) begin
      @(negedge clk);
      periph_low = 1'b1;
      @(negedge clk);
      periph_low = 1'b0;
    end else begin
      while (!drv_low && guard < 400) begin
        @(negedge clk);
        guard++;
      end
      if (expect_gap >= 0) chk(guard == expect_gap, "R3 back-to-back restart", guard, expect_gap);
    end
    while (drv_low && lowcnt < 20) begin
      lowcnt++;
      @(negedge clk);
    end
    if (qinit) chk(lowcnt == w - 1, "R5 quiet host start length", lowcnt, w - 1);
    else       chk(lowcnt == w, "R4 start length", lowcnt, w);
    chk(drv_high && !drv_low, "R6 high after start", {drv_high, drv_low}, 2'b10);
    @(negedge clk);
    chk(!drv_high && !drv_low, "R6 release after start", {drv_high, drv_low}, 2'b00);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      periph_low = req[k];
      if (drv_low || drv_high) slot_drive++;
      @(negedge clk);
      periph_low = 1'b0;
      if (k == 0 && mid_en) begin
        cfg_we = 1'b1;
        cfg_wdata = mid_val;
      end
      @(negedge clk);
      cfg_we = 1'b0;
      if (k == n - 1) chk(irq_vec == last_vec, "R9 vector held during cycle", irq_vec, last_vec);
    end
    chk(slot_drive == 0, "R7 no host drive in slots", slot_drive, 0);
    @(negedge clk);
    chk(irq_vec == exp_vec, "R7 captured vector", irq_vec, exp_vec);
    last_vec = irq_vec;
    lowcnt = 0;
    while (drv_low && lowcnt < 20) begin
      lowcnt++;
      @(negedge clk);
    end
    chk(lowcnt == stop_len, "R8 stop length", lowcnt, stop_len);
    chk(drv_high && !drv_low, "R8 high after stop", {drv_high, drv_low}, 2'b10);
  endtask

  task automatic t_reset();
    chk(cfg_rdata == 8'h10, "R1 reset config", cfg_rdata, 8'h10);
    chk(!drv_low && !drv_high, "R1 idle after reset", {drv_high, drv_low}, 0);
    chk(irq_vec == '0, "R9 vector clear after reset", irq_vec, 0);
  endtask

  task automatic t_disabled();
    periph_low = 1'b1;
    quiet_window(12, "R2 disabled ignores low line");
    periph_low = 1'b0;
    chk(irq_vec == '0, "R2 disabled vector unchanged", irq_vec, 0);
  endtask

  task automatic t_unprimed();
    wr_cfg(8'h90);
    chk(cfg_rdata == 8'h90, "R1 write readback", cfg_rdata, 8'h90);
    @(negedge clk);
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    quiet_window(12, "R10 unprimed quiet start ignored");
  endtask

  task automatic t_continuous_chain();
    wr_cfg(8'hD0);
    expect_gap = -1;
    // R11: mid-cycle write of 17 slots / width 6 must not affect this cycle
    run_frame(1'b0, 4, 21, 32'h0010_0001, 3, 1'b1, 8'hC1);
    expect_gap = 2;
    run_frame(1'b0, 6, 17, 32'hFFFF_FFFF, 3, 1'b1, 8'hD2);
    run_frame(1'b0, 8, 21, 32'h0000_0000, 3, 1'b1, 8'hD3);
    run_frame(1'b0, 4, 21, 32'h0015_5555, 3, 1'b1, 8'hFC);
    run_frame(1'b0, 4, 32, 32'h8000_0001, 2, 1'b1, 8'h90);
    expect_gap = -1;
    quiet_window(12, "R8 quiet mode stays idle after stop");
  endtask

  task automatic t_quiet();
    run_frame(1'b1, 4, 21, 32'h0000_0F00, 2, 1'b0, 8'h00);
    quiet_window(4, "R8 quiet idle after peripheral cycle");
    wr_cfg(8'h92);
    run_frame(1'b1, 8, 21, 32'h0010_0000, 2, 1'b0, 8'h00);
    quiet_window(4, "R8 quiet idle after wide start");
  endtask

  task automatic t_disable_mid();
    logic [31:0] held;
    int guard = 0;
    wr_cfg(8'hD0);
    while (!drv_low && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    repeat (10) @(negedge clk);
    held = irq_vec;
    wr_cfg(8'h50);
    @(negedge clk);
    quiet_window(10, "R2 disable mid-cycle releases line");
    chk(irq_vec == held, "R2 abandoned cycle keeps vector", irq_vec, held);
    chk(held == 32'h0010_0000, "R2 vector from last full cycle", held, 32'h0010_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    periph_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_unprimed();
    t_continuous_chain();
    t_quiet();
    t_disable_mid();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule